// File: doc/BRIEF.md
# TLB Maintenance Register Front End

This block sits between a processor's control-register bus and a software-managed translation lookaside buffer. Software programs three registers to manage the buffer: a page-address register that holds a virtual page number and a table base, an access register that holds a frame number, permission bits and a global bit, and a control register that holds an address-space identifier (PID), a way select, an install-enable bit and a load-enable bit. The buffer array is outside the block. The block drives the array's write port and read port.

Installs and readbacks happen as side effects of register writes. A write to the access register while install-enable is set stores an entry in the way named by the control register and in the set taken from the latched page number. The way select then moves on by one. A write to the control register with load-enable set reads one entry back into the three registers. When the PID changes, the block sends a one-cycle request to invalidate cached translations that belong to the old PID. Lookup and exception logic are not part of this block.

Top module: `tlb_maint`

## Requirements
- R1: A write to the access register (address 1) raises `tlbWrEn` in the same cycle only if bit 10 (install-enable) of the control register's read-back value is 1. Otherwise `tlbWrEn` stays 0.
- R2: An install goes to way `tlbWrWay`, which is the control register's way field in bits [9:8]. The set `tlbWrSet` is the low 5 bits of the latched page number.
- R3: The installed tag is {VPN[19:0], G, valid, PID[7:0]}, 30 bits with the PID at the bottom. G is bit 24 of the written access value. Valid is 1 exactly when the latched page number is below 0xC0000. The PID is the one last written to the control register, not its read-back value.
- R4: The installed data word is bits [23:0] of the written access value: C at bit 23, R at 22, W at 21, X at 20, and the frame number in [19:0].
- R5: After each install the way field advances by one and wraps from 3 to 0.
- R6: A write to the control register (address 2) with bit 11 (load-enable) set raises `tlbRdEn` in that cycle. The read way is bits [9:8] of the written value and the read set is the low 5 bits of the latched page number. The array answers one cycle later, and the registers take the answer at the next clock edge.
- R7: After a load, the access register reads back as {its unchanged ignored field [31:25], entry G at bit 24, entry data in [23:0]}.
- R8: After a load, the control register reads back as the written value with its PID field replaced by the entry's PID. The page-address register's VPN field in [21:2] reads back as the entry's page number.
- R9: A write to the page-address register (address 0) changes the read-back table base in [31:22] right away. The read-back VPN field stays the same. The written page number is still latched and used for installs and reads.
- R10: A write to the access register never changes its read-back value.
- R11: A control-register write whose PID differs from the last written PID raises `invReq` for the following cycle only, with `invPid` set to the old PID. A write with the same PID raises no request.
- R12: Address 3 reads as zero. All three registers read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select: 0 page-address, 1 access, 2 control |
| regWrEn | input | 1 | Single-cycle write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read-back value of the selected register |
| tlbWrEn | output | 1 | Array write enable |
| tlbWrWay | output | 2 | Array write way |
| tlbWrSet | output | 5 | Array write set |
| tlbWrTag | output | 30 | Tag to store |
| tlbWrData | output | 24 | Data word to store |
| tlbRdEn | output | 1 | Array read enable |
| tlbRdWay | output | 2 | Array read way |
| tlbRdSet | output | 5 | Array read set |
| tlbRdTag | input | 30 | Tag returned by the array one cycle after a read |
| tlbRdData | input | 24 | Data returned by the array one cycle after a read |
| invReq | output | 1 | One-cycle request to invalidate the old PID's translations |
| invPid | output | 8 | PID to invalidate |

## Verification
The assertions assume that the array returns its answer exactly one cycle after `tlbRdEn`. They also assume that the bus does not write a register in the cycle when that answer is being loaded. The bench's array model answers with that fixed latency. Its driver always leaves at least one idle cycle after a load-enable write before the next bus access. The stimulus uses only power-of-two way counts and way values below four, so the wrap rule is never asked to handle an out-of-range way.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;

  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ADDR_PAGE = 2'd0,
    ADDR_ACC  = 2'd1,
    ADDR_MISC = 2'd2,
    ADDR_NONE = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPage;
    logic wrAcc;
    logic wrMisc;
    logic install;
    logic readReq;
    logic loadBack;
    logic pidChg;
  } strobe_t;

endpackage

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl
  import tlb_maint_pkg::*;
#(
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic             loadBit,
  input  logic [PID_W-1:0] newPid,
  input  logic [PID_W-1:0] oldPid,
  input  logic             weNow,
  output strobe_t          st
);

  logic loadPend;

  always_comb begin
    st         = '0;
    st.wrPage  = regWrEn && (regSel_e'(regAddr) == ADDR_PAGE);
    st.wrAcc   = regWrEn && (regSel_e'(regAddr) == ADDR_ACC);
    st.wrMisc  = regWrEn && (regSel_e'(regAddr) == ADDR_MISC);
    st.install = st.wrAcc && weNow;
    st.readReq = st.wrMisc && loadBit;
    st.pidChg  = st.wrMisc && (newPid != oldPid);
    st.loadBack = loadPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) loadPend <= 1'b0;
    else       loadPend <= st.readReq;
  end

  // R6: loads only follow an array read by one cycle
  a_r6_load_after_read: assert property (@(posedge clk) disable iff (!rstN)
    st.loadBack |-> $past(st.readReq));

endmodule

// File: rtl/tlb_maint_datapath.sv
module tlb_maint_datapath
  import tlb_maint_pkg::*;
#(
  parameter int          NUM_WAYS    = 4,
  parameter int          NUM_SETS    = 32,
  parameter int          VPN_W       = 20,
  parameter int          PFN_W       = 20,
  parameter int          PID_W       = 8,
  parameter int unsigned VALID_LIMIT = 32'h000C_0000,
  localparam int WAY_W  = $clog2(NUM_WAYS),
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int TAG_W  = VPN_W + 2 + PID_W,
  localparam int DATA_W = PFN_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [TAG_W-1:0]  tlbRdTag,
  input  logic [DATA_W-1:0] tlbRdData,
  output logic [REG_W-1:0]  regRdData,
  output logic              weNow,
  output logic [PID_W-1:0]  pidWr,
  output logic [WAY_W-1:0]  wrWay,
  output logic [SET_W-1:0]  wrSet,
  output logic [TAG_W-1:0]  wrTag,
  output logic [DATA_W-1:0] wrData,
  output logic [WAY_W-1:0]  rdWay,
  output logic [SET_W-1:0]  rdSet,
  output logic              invReq,
  output logic [PID_W-1:0]  invPid
);

  localparam int VPN_LSB  = 2;
  localparam int BASE_LSB = VPN_LSB + VPN_W;
  localparam int BASE_W   = REG_W - BASE_LSB;
  localparam int G_BIT    = DATA_W;
  localparam int WAY_LSB  = PID_W;
  localparam int WE_BIT   = WAY_LSB + WAY_W;

  logic [BASE_W-1:0] pageBase;
  logic [VPN_W-1:0]  vpnWr;
  logic [VPN_W-1:0]  pageVpnRd;
  logic [REG_W-1:0]  accRd;
  logic [REG_W-1:0]  miscRd;
  logic [WAY_W-1:0]  wayNow;
  logic [WAY_W-1:0]  nextWay;
  logic              vpnValid;
  logic [VPN_W-1:0]  rdVpn;
  logic              rdG;
  logic [PID_W-1:0]  rdPid;
  logic              unusedRdValid;

  assign wayNow   = miscRd[WAY_LSB +: WAY_W];
  assign nextWay  = (wayNow == WAY_W'(NUM_WAYS - 1)) ? '0 : wayNow + 1'b1;
  assign weNow    = miscRd[WE_BIT];
  assign vpnValid = (32'(vpnWr) < VALID_LIMIT);

  // install port
  assign wrWay  = wayNow;
  assign wrSet  = vpnWr[SET_W-1:0];
  assign wrTag  = {vpnWr, regWrData[G_BIT], vpnValid, pidWr};
  assign wrData = regWrData[DATA_W-1:0];

  // read port
  assign rdWay = regWrData[WAY_LSB +: WAY_W];
  assign rdSet = vpnWr[SET_W-1:0];

  assign rdVpn         = tlbRdTag[TAG_W-1 -: VPN_W];
  assign rdG           = tlbRdTag[PID_W + 1];
  assign rdPid         = tlbRdTag[PID_W-1:0];
  assign unusedRdValid = tlbRdTag[PID_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageBase  <= '0;
      vpnWr     <= '0;
      pageVpnRd <= '0;
      accRd     <= '0;
      miscRd    <= '0;
      pidWr     <= '0;
      invReq    <= 1'b0;
      invPid    <= '0;
    end else begin
      invReq <= st.pidChg;
      if (st.pidChg) invPid <= pidWr;
      if (st.wrPage) begin
        pageBase <= regWrData[REG_W-1:BASE_LSB];
        vpnWr    <= regWrData[VPN_LSB +: VPN_W];
      end
      if (st.wrMisc) begin
        miscRd <= regWrData;
        pidWr  <= regWrData[PID_W-1:0];
      end
      if (st.install) miscRd[WAY_LSB +: WAY_W] <= nextWay;
      if (st.loadBack) begin
        accRd              <= {accRd[REG_W-1:G_BIT+1], rdG, tlbRdData};
        miscRd[PID_W-1:0]  <= rdPid;
        pageVpnRd          <= rdVpn;
      end
    end
  end

  always_comb begin
    unique case (regSel_e'(regAddr))
      ADDR_PAGE: regRdData = {pageBase, pageVpnRd, {VPN_LSB{1'b0}}};
      ADDR_ACC:  regRdData = accRd;
      ADDR_MISC: regRdData = miscRd;
      default:   regRdData = '0;
    endcase
  end

  // R5: way select advances and wraps after an install
  a_r5_way_wraps: assert property (@(posedge clk) disable iff (!rstN)
    st.install |=> wayNow == (($past(wayNow) == WAY_W'(NUM_WAYS - 1)) ?
                              '0 : $past(wayNow) + 1'b1));

  // R9: read-back VPN moves only on a load
  a_r9_vpn_holds: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadBack |=> $stable(pageVpnRd));

  // R10: read-back access value moves only on a load
  a_r10_acc_holds: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadBack |=> $stable(accRd));

endmodule

// File: rtl/tlb_maint.sv
module tlb_maint
  import tlb_maint_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 32,
  parameter int VPN_W    = 20,
  parameter int PFN_W    = 20,
  parameter int PID_W    = 8,
  localparam int WAY_W  = $clog2(NUM_WAYS),
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int TAG_W  = VPN_W + 2 + PID_W,
  localparam int DATA_W = PFN_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              tlbWrEn,
  output logic [WAY_W-1:0]  tlbWrWay,
  output logic [SET_W-1:0]  tlbWrSet,
  output logic [TAG_W-1:0]  tlbWrTag,
  output logic [DATA_W-1:0] tlbWrData,
  output logic              tlbRdEn,
  output logic [WAY_W-1:0]  tlbRdWay,
  output logic [SET_W-1:0]  tlbRdSet,
  input  logic [TAG_W-1:0]  tlbRdTag,
  input  logic [DATA_W-1:0] tlbRdData,
  output logic              invReq,
  output logic [PID_W-1:0]  invPid
);

  localparam int LOAD_BIT = PID_W + WAY_W + 1;

  strobe_t          st;
  logic             weNow;
  logic [PID_W-1:0] pidWr;

  tlb_maint_ctrl #(.PID_W(PID_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .loadBit (regWrData[LOAD_BIT]),
    .newPid  (regWrData[PID_W-1:0]),
    .oldPid  (pidWr),
    .weNow   (weNow),
    .st      (st)
  );

  tlb_maint_datapath #(
    .NUM_WAYS (NUM_WAYS),
    .NUM_SETS (NUM_SETS),
    .VPN_W    (VPN_W),
    .PFN_W    (PFN_W),
    .PID_W    (PID_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .tlbRdTag  (tlbRdTag),
    .tlbRdData (tlbRdData),
    .regRdData (regRdData),
    .weNow     (weNow),
    .pidWr     (pidWr),
    .wrWay     (tlbWrWay),
    .wrSet     (tlbWrSet),
    .wrTag     (tlbWrTag),
    .wrData    (tlbWrData),
    .rdWay     (tlbRdWay),
    .rdSet     (tlbRdSet),
    .invReq    (invReq),
    .invPid    (invPid)
  );

  assign tlbWrEn = st.install;
  assign tlbRdEn = st.readReq;

  // R11: an invalidate request only follows a control-register write
  a_r11_inv_after_misc: assert property (@(posedge clk) disable iff (!rstN)
    invReq |-> $past(regWrEn && (regAddr == 2'd2)));

endmodule

// File: tb/sim_tlb_maint.sv
`timescale 1ns/1ps
module sim_tlb_maint;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        tlbWrEn;
  logic [1:0]  tlbWrWay;
  logic [4:0]  tlbWrSet;
  logic [29:0] tlbWrTag;
  logic [23:0] tlbWrData;
  logic        tlbRdEn;
  logic [1:0]  tlbRdWay;
  logic [4:0]  tlbRdSet;
  logic [29:0] tlbRdTag;
  logic [23:0] tlbRdData;
  logic        invReq;
  logic [7:0]  invPid;

  always #4 clk = ~clk;

  tlb_maint u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .tlbWrEn(tlbWrEn), .tlbWrWay(tlbWrWay), .tlbWrSet(tlbWrSet),
    .tlbWrTag(tlbWrTag), .tlbWrData(tlbWrData),
    .tlbRdEn(tlbRdEn), .tlbRdWay(tlbRdWay), .tlbRdSet(tlbRdSet),
    .tlbRdTag(tlbRdTag), .tlbRdData(tlbRdData),
    .invReq(invReq), .invPid(invPid)
  );

  // array model: one-cycle read latency
  logic [29:0] mTag  [4][32];
  logic [23:0] mData [4][32];
  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 32; s++) begin
        mTag[w][s]  = '0;
        mData[w][s] = '0;
      end
    tlbRdTag  = '0;
    tlbRdData = '0;
  end
  always @(posedge clk) begin
    if (tlbWrEn) begin
      mTag[tlbWrWay][tlbWrSet]  <= tlbWrTag;
      mData[tlbWrWay][tlbWrSet] <= tlbWrData;
    end
    if (tlbRdEn) begin
      tlbRdTag  <= mTag[tlbRdWay][tlbRdSet];
      tlbRdData <= mData[tlbRdWay][tlbRdSet];
    end
  end

  // scoreboard
  typedef struct {
    int          sel;
    logic [63:0] exp;
    string       req;
  } item_t;
  item_t expQ[$];
  event  probe;
  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;

  localparam int S_RD = 0, S_WREN = 1, S_WWAY = 2, S_WSET = 3, S_WTAG = 4,
                 S_WDATA = 5, S_RDEN = 6, S_RWAY = 7, S_RSET = 8,
                 S_INV = 9, S_INVPID = 10;

  function automatic logic [63:0] observe(int sel);
    case (sel)
      S_RD:     return 64'(regRdData);
      S_WREN:   return 64'(tlbWrEn);
      S_WWAY:   return 64'(tlbWrWay);
      S_WSET:   return 64'(tlbWrSet);
      S_WTAG:   return 64'(tlbWrTag);
      S_WDATA:  return 64'(tlbWrData);
      S_RDEN:   return 64'(tlbRdEn);
      S_RWAY:   return 64'(tlbRdWay);
      S_RSET:   return 64'(tlbRdSet);
      S_INV:    return 64'(invReq);
      default:  return 64'(invPid);
    endcase
  endfunction

  // monitor
  initial begin
    forever begin
      @(probe);
      #2;
      while (expQ.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it  = expQ.pop_front();
        act = observe(it.sel);
        vectors++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int sel, input logic [63:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic fire();
    -> probe;
    #3;
  endtask

  function automatic logic [29:0] mkTag(input logic [19:0] vpn, input logic g,
                                        input logic [7:0] pid);
    return {vpn, g, (vpn < 20'hC0000), pid};
  endfunction

  // drive write; caller pushes same-cycle checks then calls busEnd
  task automatic busSet(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
  endtask
  task automatic busEnd();
    @(negedge clk);
    regWrEn = 1'b0;
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busSet(a, d);
    busEnd();
  endtask
  task automatic rdChk(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    push(S_RD, 64'(exp), req);
    fire();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12: reset state and unmapped address
    rdChk(2'd0, 32'h0, "R12 page reset");
    rdChk(2'd1, 32'h0, "R12 access reset");
    rdChk(2'd2, 32'h0, "R12 control reset");

    // R9: page write keeps VPN read-back, base updates
    wr(2'd0, (32'h155 << 22) | (32'h12345 << 2));
    rdChk(2'd0, 32'h155 << 22, "R9 page base only");

    // R11: PID 0 -> 0x3A raises invalidate of PID 0
    wr(2'd2, 32'h0000_003A);
    push(S_INV, 64'd1, "R11 inv pulse");
    push(S_INVPID, 64'd0, "R11 old pid");
    fire();
    @(negedge clk);
    push(S_INV, 64'd0, "R11 pulse one cycle");
    fire();

    // R1: no install without enable; R10: read-back unchanged
    busSet(2'd1, 32'hFFDA_BCDE);
    push(S_WREN, 64'd0, "R1 no install when disabled");
    fire();
    busEnd();
    rdChk(2'd1, 32'h0, "R10 access read-back unchanged");

    // enable install, way 1, same PID: no invalidate
    wr(2'd2, 32'h0000_053A);
    push(S_INV, 64'd0, "R11 same pid no pulse");
    fire();

    // R1..R4: install at way 1 set 5
    busSet(2'd1, 32'hFFDA_BCDE);
    push(S_WREN, 64'd1, "R1 install enabled");
    push(S_WWAY, 64'd1, "R2 way");
    push(S_WSET, 64'd5, "R2 set");
    push(S_WTAG, 64'(mkTag(20'h12345, 1'b1, 8'h3A)), "R3 tag");
    push(S_WDATA, 64'(24'hDABCDE), "R4 data bits");
    fire();
    busEnd();
    rdChk(2'd2, 32'h0000_063A, "R5 way advanced");
    rdChk(2'd1, 32'h0, "R10 access after install");

    // R3: invalid VPN
    wr(2'd0, 32'h0000_0000 | (32'hC0001 << 2));
    busSet(2'd1, 32'h0001_2345);
    push(S_WTAG, 64'(mkTag(20'hC0001, 1'b0, 8'h3A)), "R3 valid clear at limit");
    push(S_WWAY, 64'd2, "R2 way 2");
    push(S_WSET, 64'd1, "R2 set 1");
    fire();
    busEnd();

    // R5: install at way 3 then wrap to 0
    wr(2'd0, 32'hBFFFF << 2);
    busSet(2'd1, 32'h01F0_0077);
    push(S_WTAG, 64'(mkTag(20'hBFFFF, 1'b1, 8'h3A)), "R3 valid just below limit");
    push(S_WDATA, 64'(24'hF00077), "R4 all perms");
    push(S_WWAY, 64'd3, "R2 way 3");
    fire();
    busEnd();
    rdChk(2'd2, 32'h0000_043A, "R5 way wraps to 0");

    // R6..R8: load way 1 set 5, PID 0x11 written
    wr(2'd0, (32'h155 << 22) | (32'h12345 << 2));
    busSet(2'd2, 32'h0000_0911);
    push(S_RDEN, 64'd1, "R6 read enable");
    push(S_RWAY, 64'd1, "R6 read way");
    push(S_RSET, 64'd5, "R6 read set");
    fire();
    busEnd();
    push(S_INV, 64'd1, "R11 pulse on change");
    push(S_INVPID, 64'h3A, "R11 old pid 3A");
    fire();
    rdChk(2'd2, 32'h0000_093A, "R8 pid from entry");
    rdChk(2'd0, (32'h155 << 22) | (32'h12345 << 2), "R8 vpn from entry");
    rdChk(2'd1, 32'h01DA_BCDE, "R7 access from entry");

    // R1: read-back control has install-enable clear
    busSet(2'd1, 32'h0030_0456);
    push(S_WREN, 64'd0, "R1 disabled after load");
    fire();
    busEnd();

    // R3: PID used is last written (0x11), not read-back (0x3A)
    wr(2'd2, 32'h0000_0411);
    push(S_INV, 64'd0, "R11 written pid compared");
    fire();
    busSet(2'd1, 32'h0030_0456);
    push(S_WTAG, 64'(mkTag(20'h12345, 1'b0, 8'h11)), "R3 pid last written");
    push(S_WWAY, 64'd0, "R2 way 0");
    fire();
    busEnd();
    rdChk(2'd2, 32'h0000_0511, "R5 way 0 to 1");

    // R9/R8: page write then load way 3 set 31
    wr(2'd0, 32'hBFFFF << 2);
    rdChk(2'd0, 32'h12345 << 2, "R9 vpn read-back kept");
    wr(2'd2, 32'h0000_0B11);
    @(negedge clk);
    rdChk(2'd1, 32'h01F0_0077, "R7 second load");
    rdChk(2'd2, 32'h0000_0B3A, "R8 second pid");
    rdChk(2'd0, 32'hBFFFF << 2, "R8 second vpn");
    rdChk(2'd3, 32'h0, "R12 unmapped reads zero");

    done = 1;
    finishRun();
  end

endmodule